// File: doc/BRIEF.md
# 128-bit Translation Root Register

This block is the supervisor register that tells a 128-bit core how to translate virtual addresses. It stores three fields: a translation mode, an address-space identifier (ASID) and the page number of the root page table. The same values drive the page walker through dedicated outputs. Software reaches the register through a simple CSR port with separate read and write strobes. The core also supplies its current privilege level and a trap-virtual-memory control bit. With that bit set, supervisor code may not touch translation.

A write is screened in two ways. The requested mode must be one of the three legal encodings, and at least one defined field must differ from what is stored. A write that fails either test does nothing, and it does not trap. A write that passes both tests is either committed, or it is refused with an illegal-instruction trap when supervisor access is blocked. A committed write that changes the ASID raises a single-cycle request to flush the TLB. A build-time parameter removes the translation hardware. The register then reads as zero and ignores all writes.

Top module: `xlate_root_csr`

## Requirements
- R1: After reset all 128 bits read as zero, which selects bare mode (mode 0), ASID 0 and root page 0.
- R2: The mode sits in bits 127:120, the ASID in bits 119:88 and the root page number in bits 49:0. All other bits read as zero, and any value written to them is discarded.
- R3: Only the mode values 0, 12 and 13, compared over all 8 bits, are legal. A write carrying any other mode leaves the register unchanged and raises no trap.
- R4: A write with a legal mode whose three fields all equal the stored ones has no effect. It raises no trap, even when supervisor access is blocked.
- R5: A read while privilege is supervisor (encoding 1) and the trap-virtual-memory input is high asserts the trap output, and the read data is zero.
- R6: Under the same blocked condition, a write that would otherwise take effect asserts the trap output and leaves the register unchanged.
- R7: `tlb_flush` is high for exactly the one cycle after the clock edge that commits a write changing at least one ASID bit. Committed writes that leave the ASID unchanged produce no flush.
- R8: With `HAS_MMU` = 0, reads return zero, writes change nothing, and neither trap nor flush is ever raised.
- R9: Read data is combinational. It shows the stored value during the same cycle that the read strobe is high, and it is zero when no read is requested.
- R10: User (0) or machine (3) privilege, or a low trap-virtual-memory input, never causes a trap. Legal, changing writes then commit on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_re | input | 1 | Read strobe for this register |
| csr_we | input | 1 | Write strobe for this register |
| csr_wdata | input | 128 | Write value |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| trap_vm | input | 1 | Blocks supervisor access to translation when high |
| csr_rdata | output | 128 | Read value, combinational |
| illegal_trap | output | 1 | Illegal-instruction trap request, combinational |
| tlb_flush | output | 1 | One-cycle TLB flush request |
| cur_mode | output | 8 | Stored translation mode |
| cur_asid | output | 32 | Stored address-space identifier |
| root_ppn | output | 50 | Stored root page-table page number |

## Verification
Every cycle, the assertions check four things. Any flush coincides with an ASID change. A blocked write leaves the stored fields unchanged. An illegal-mode write neither traps nor alters state. A blocked read traps and returns zero. The bench's scenarios cover the rest, because each needs a specific sequence of stimulus. These are the reset value, the discarding of reserved bits, mode values that match a legal one only in the low nibble, unchanged writes under blocking, back-to-back ASID changes, and the build with translation removed. The bench checks each of them against a behavioural model on every clock.

// File: rtl/xlate_root_csr.sv
module xlate_root_csr #(
  parameter bit HAS_MMU = 1'b1,
  parameter int MODE_W  = 8,
  parameter int ASID_W  = 32,
  parameter int PPN_W   = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_re,
  input  logic               csr_we,
  input  logic [127:0]       csr_wdata,
  input  logic [1:0]         priv_lvl,
  input  logic               trap_vm,
  output logic [127:0]       csr_rdata,
  output logic               illegal_trap,
  output logic               tlb_flush,
  output logic [MODE_W-1:0]  cur_mode,
  output logic [ASID_W-1:0]  cur_asid,
  output logic [PPN_W-1:0]   root_ppn
);

  localparam int REG_W    = 128;
  localparam int MODE_LSB = REG_W - MODE_W;
  localparam int ASID_LSB = MODE_LSB - ASID_W;
  localparam int GAP_W    = ASID_LSB - PPN_W;
  localparam logic [MODE_W-1:0] MODE_BARE = '0;
  localparam logic [MODE_W-1:0] MODE_L3   = MODE_W'(12);
  localparam logic [MODE_W-1:0] MODE_L4   = MODE_W'(13);
  localparam logic [1:0] PRIV_SUP = 2'd1;

  logic [MODE_W-1:0] new_mode;
  logic [ASID_W-1:0] new_asid;
  logic [PPN_W-1:0]  new_ppn;
  logic mode_ok, differs, hits, blocked, commit;
  logic flush_q;

  assign new_mode = csr_wdata[REG_W-1:MODE_LSB];
  assign new_asid = csr_wdata[MODE_LSB-1:ASID_LSB];
  assign new_ppn  = csr_wdata[PPN_W-1:0];

  assign mode_ok = (new_mode == MODE_BARE) || (new_mode == MODE_L3) || (new_mode == MODE_L4);
  assign differs = (new_mode != cur_mode) || (new_asid != cur_asid) || (new_ppn != root_ppn);
  assign blocked = HAS_MMU && (priv_lvl == PRIV_SUP) && trap_vm;
  assign hits    = HAS_MMU && csr_we && mode_ok && differs;
  assign commit  = hits && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= '0;
      cur_asid <= '0;
      root_ppn <= '0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= commit && (new_asid != cur_asid);
      if (commit) begin
        cur_mode <= new_mode;
        cur_asid <= new_asid;
        root_ppn <= new_ppn;
      end
    end
  end

  assign tlb_flush    = flush_q;
  assign illegal_trap = blocked && ((HAS_MMU && csr_re) || hits);
  assign csr_rdata    = (HAS_MMU && csr_re && !blocked)
                        ? {cur_mode, cur_asid, {GAP_W{1'b0}}, root_ppn}
                        : '0;

  // R7
  flush_on_asid_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> (cur_asid != $past(cur_asid)));

  // R6
  blocked_write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_re && illegal_trap) |=>
      ($stable(cur_mode) && $stable(cur_asid) && $stable(root_ppn)));

  // R3
  bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_re && !mode_ok) |-> !illegal_trap);

  // R3
  bad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !mode_ok) |=>
      ($stable(cur_mode) && $stable(cur_asid) && $stable(root_ppn)));

  // R5
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_MMU && csr_re && priv_lvl == PRIV_SUP && trap_vm) |->
      (illegal_trap && csr_rdata == '0));

endmodule

// File: tb/tb_xlate_root_csr.sv
module tb_xlate_root_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic re = 1'b0, we = 1'b0, tvm = 1'b0;
  logic [127:0] wd = '0;
  logic [1:0] priv = 2'd3;
  logic [127:0] rd, rd_n;
  logic trap, trap_n, fl, fl_n;
  logic [7:0] md, md_n;
  logic [31:0] as, as_n;
  logic [49:0] pp, pp_n;

  always #10 clk = ~clk;

  xlate_root_csr dut (.clk(clk), .rst_n(rst_n), .csr_re(re), .csr_we(we), .csr_wdata(wd),
    .priv_lvl(priv), .trap_vm(tvm), .csr_rdata(rd), .illegal_trap(trap), .tlb_flush(fl),
    .cur_mode(md), .cur_asid(as), .root_ppn(pp));

  xlate_root_csr #(.HAS_MMU(1'b0)) dut_nommu (.clk(clk), .rst_n(rst_n), .csr_re(re), .csr_we(we),
    .csr_wdata(wd), .priv_lvl(priv), .trap_vm(tvm), .csr_rdata(rd_n), .illegal_trap(trap_n),
    .tlb_flush(fl_n), .cur_mode(md_n), .cur_asid(as_n), .root_ppn(pp_n));

  int checks = 0, errors = 0;
  logic [127:0] m_reg = '0;
  logic m_flush = 1'b0;
  localparam logic [127:0] FIELDS = {8'hFF, 32'hFFFF_FFFF, 38'h0, {50{1'b1}}};

  function automatic logic [127:0] pack(input logic [7:0] m, input logic [31:0] a,
                                        input logic [49:0] p, input logic [37:0] junk);
    return {m, a, junk, p};
  endfunction

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic w, input logic r, input logic [127:0] d,
                     input logic [1:0] p, input logic t);
    logic blk, legal, eff;
    logic [127:0] nv;
    @(negedge clk);
    we = w; re = r; wd = d; priv = p; tvm = t;
    blk = (p == 2'd1) && t;
    nv = d & FIELDS;
    legal = (d[127:120] == 8'd0) || (d[127:120] == 8'd12) || (d[127:120] == 8'd13);
    eff = w && legal && (nv != m_reg);
    #2;
    chk(tag, "rdata", rd, (r && !blk) ? m_reg : 128'h0);
    chk(tag, "trap", {127'h0, trap}, {127'h0, blk && (r || eff)});
    chk(tag, "flush", {127'h0, fl}, {127'h0, m_flush});
    chk(tag, "fields", {md, as, 38'h0, pp}, m_reg);
    chk("R8", "nommu", {rd_n[127:3], trap_n, fl_n, |{md_n, as_n, pp_n}}, 128'h0);
    @(posedge clk);
    m_flush = eff && !blk && (nv[119:88] != m_reg[119:88]);
    if (eff && !blk) m_reg = nv;
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1'b0, 1'b0, '0, 2'd3, 1'b0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", 1'b0, 1'b1, '0, 2'd3, 1'b0);
    // R2 R7: junk in reserved bits, ASID change flushes
    cyc("R2", 1'b1, 1'b0, pack(8'd12, 32'hA5A5_0001, 50'h2_3456_789A_BCDE, 38'h3F_FFFF_FFFF), 2'd3, 1'b0);
    cyc("R7", 1'b0, 1'b1, '0, 2'd3, 1'b0);
    cyc("R9", 1'b0, 1'b1, '0, 2'd0, 1'b1);
    // R3: illegal modes, incl. one matching a legal value in the low nibble
    cyc("R3", 1'b1, 1'b0, pack(8'd5, 32'h1, 50'h1, 38'h0), 2'd3, 1'b0);
    cyc("R3", 1'b1, 1'b1, pack(8'h8C, 32'h2, 50'h2, 38'h0), 2'd1, 1'b0);
    cyc("R3", 1'b1, 1'b0, pack(8'd14, 32'h3, 50'h3, 38'h0), 2'd1, 1'b1);
    idle("R3");
    // R4: same fields under blocking, reserved junk differs
    cyc("R4", 1'b1, 1'b0, pack(8'd12, 32'hA5A5_0001, 50'h2_3456_789A_BCDE, 38'h12_3456), 2'd1, 1'b1);
    // R6 R5
    cyc("R6", 1'b1, 1'b0, pack(8'd13, 32'hA5A5_0001, 50'h7, 38'h0), 2'd1, 1'b1);
    idle("R6");
    cyc("R5", 1'b0, 1'b1, '0, 2'd1, 1'b1);
    // R10 R7: ppn-only change in supervisor without blocking, no flush
    cyc("R10", 1'b1, 1'b0, pack(8'd12, 32'hA5A5_0001, 50'h44, 38'h0), 2'd1, 1'b0);
    cyc("R7", 1'b0, 1'b1, '0, 2'd1, 1'b0);
    cyc("R10", 1'b1, 1'b0, pack(8'd13, 32'hA5A5_0001, 50'h55, 38'h0), 2'd0, 1'b1);
    cyc("R10", 1'b1, 1'b1, pack(8'd13, 32'h0000_0F00, 50'h55, 38'h0), 2'd3, 1'b1);
    // R7 back-to-back ASID changes
    cyc("R7", 1'b1, 1'b0, pack(8'd0, 32'h0000_0F01, 50'h0, 38'h0), 2'd3, 1'b0);
    cyc("R7", 1'b1, 1'b0, pack(8'd0, 32'h8000_0F01, 50'h0, 38'h0), 2'd3, 1'b0);
    idle("R7");
    idle("R7");
    cyc("R9", 1'b0, 1'b1, '0, 2'd3, 1'b0);
    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); m_reg = '0; m_flush = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", 1'b0, 1'b1, '0, 2'd3, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule